// File: doc/BRIEF.md
# Flag-Setting Data-Processing ALU

This block is the integer execute unit of a 32-bit load-store core. Each cycle it takes two operands and an operation code and computes one of ten data-processing operations in combinational logic: five bitwise operations (and, or, exclusive-or, clear-bits, inverted move), two additions (plain and carry-in) and three flag-only operations (compare, test, test-equivalence). The result and a write enable for the register file leave the block in the same cycle.

The four condition flags (negative, zero, carry, overflow) are registered inside the block and are visible on its outputs. They change at the clock edge that ends the cycle in which the operation was presented. A per-instruction set-flags input decides whether bitwise and additive operations touch the flags. The three flag-only operations always update them. The carry-in of the carry-add is the registered carry flag as it stands in that cycle. Operand shifting, decode and conditional execution live elsewhere.

Top module: `dp_alu`

## Requirements
- R1: While reset (active-low `rst_n`) is asserted, and after it is released, the four flags read 0 until the first flag update.
- R2: The bitwise operations drive `result` in the same cycle with `result_we` = 1. The codes are 0 (A and B), 1 (A or B), 2 (A xor B), 3 (A and not B) and 4 (not B).
- R3: Code 5 gives A + B and code 6 gives A + B + C, both modulo 2^32 with `result_we` = 1. Here C is the carry flag output during that cycle.
- R4: The flag-only operations are code 7 (compare, value A − B), code 8 (test, value A and B) and code 9 (test-equivalence, value A xor B). They hold `result_we` = 0 and `result` = 0. They update the flags at the next edge whatever `set_flags` is.
- R5: On any flag update, N takes bit 31 of the operation's value, and Z is 1 exactly when that value is zero.
- R6: On an update by codes 5 and 6, C takes the carry out of bit 31. On an update by code 7, C is 1 exactly when A ≥ B as unsigned numbers.
- R7: On an update by codes 5, 6 and 7, V is 1 exactly when the true signed result of the addition or subtraction falls outside the 32-bit two's-complement range.
- R8: Flag updates by codes 0–4 and 8–9 change only N and Z. C and V keep their values.
- R9: For codes 0–6 presented with `set_flags` = 0, all four flags keep their values at the next edge.
- R10: Codes 10–15 are reserved. They give `result` = 0 and `result_we` = 0, and leave all flags unchanged even with `set_flags` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| opcode | input | 4 | Operation code (see R2–R4, R10) |
| set_flags | input | 1 | Allow flag update for codes 0–6 |
| result | output | 32 | Operation result, zero when not written |
| result_we | output | 1 | Result is to be written to the destination |
| flag_n | output | 1 | Registered negative flag |
| flag_z | output | 1 | Registered zero flag |
| flag_c | output | 1 | Registered carry flag |
| flag_v | output | 1 | Registered overflow flag |

## Verification
The hardest state to reach is a carry-add whose carry-in matters. The carry flag must first be set or cleared by an earlier flag-writing operation, and the value it holds at that point depends on the whole preceding sequence. The stimulus therefore chains operations on purpose. An add that wraps sets the carry flag, and a carry-add follows with `set_flags` both high and low. A compare that borrows clears the carry flag, and a carry-add follows that as well. A bitwise update sits in between to show that C survives it. Random sequences then mix all codes with random `set_flags`, against a reference model that carries its own copy of the flags.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

    localparam int unsigned OPC_W = 4;

    typedef enum logic [OPC_W-1:0] {
        OPC_AND = 4'd0,
        OPC_ORR = 4'd1,
        OPC_EOR = 4'd2,
        OPC_BIC = 4'd3,
        OPC_MVN = 4'd4,
        OPC_ADD = 4'd5,
        OPC_ADC = 4'd6,
        OPC_CMP = 4'd7,
        OPC_TST = 4'd8,
        OPC_TEQ = 4'd9
    } alu_opc_e;

    typedef enum logic [2:0] {
        LU_AND,
        LU_ORR,
        LU_EOR,
        LU_BIC,
        LU_INV
    } lu_sel_e;

    typedef enum logic [1:0] {
        FU_NONE,
        FU_NZ,
        FU_ALL
    } flag_upd_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

endpackage

// File: rtl/dp_alu_logic.sv
module dp_alu_logic
    import dp_alu_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  lu_sel_e      sel_i,
    output logic [W-1:0] y_o
);

    always_comb begin
        unique case (sel_i)
            LU_AND:  y_o = a_i & b_i;
            LU_ORR:  y_o = a_i | b_i;
            LU_EOR:  y_o = a_i ^ b_i;
            LU_BIC:  y_o = a_i & ~b_i;
            LU_INV:  y_o = ~b_i;
            default: y_o = '0;
        endcase
    end

endmodule

// File: rtl/dp_alu_addsub.sv
module dp_alu_addsub #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o,
    output logic         ovf_o
);

    logic [W-1:0] b_eff;
    logic [W:0]   wide;

    always_comb begin
        // subtraction is A + ~B + 1, so carry out means "no borrow"
        b_eff  = sub_i ? ~b_i : b_i;
        wide   = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, cin_i};
        sum_o  = wide[W-1:0];
        cout_o = wide[W];
        ovf_o  = (a_i[W-1] == b_eff[W-1]) && (sum_o[W-1] != a_i[W-1]);
    end

endmodule

// File: rtl/dp_alu_flags.sv
module dp_alu_flags
    import dp_alu_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  flag_upd_e upd_i,
    input  nzcv_t     new_i,
    output nzcv_t     flags_o
);

    nzcv_t flags_d, flags_q;

    always_comb begin
        flags_d = flags_q;
        unique case (upd_i)
            FU_NZ: begin
                flags_d.n = new_i.n;
                flags_d.z = new_i.z;
            end
            FU_ALL:  flags_d = new_i;
            default: flags_d = flags_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags_o = flags_q;

    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i == FU_NONE) |=> $stable(flags_q)); // R9

    AST_CV_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i == FU_NZ) |=> (flags_q.c == $past(flags_q.c)) && (flags_q.v == $past(flags_q.v))); // R8

endmodule

// File: rtl/dp_alu.sv
module dp_alu
    import dp_alu_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [OPC_W-1:0]  opcode,
    input  logic              set_flags,
    output logic [DATA_W-1:0] result,
    output logic              result_we,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_c,
    output logic              flag_v
);

    localparam logic [DATA_W-1:0] ZERO_W = '0;

    typedef struct packed {
        lu_sel_e       lu_sel;
        logic          sub;
        logic          cin;
        logic          use_sum;
        logic          we;
        flag_upd_e     upd;
    } ctrl_t;

    ctrl_t             ctrl_d;
    nzcv_t             flags_q;
    nzcv_t             nzcv_d;
    logic [DATA_W-1:0] lu_y;
    logic [DATA_W-1:0] sum;
    logic              cout;
    logic              ovf;
    logic [DATA_W-1:0] value_d;

    // decode of the operation into unit controls
    always_comb begin
        ctrl_d         = '0;
        ctrl_d.lu_sel  = LU_AND;
        ctrl_d.upd     = FU_NONE;
        unique case (opcode)
            OPC_AND, OPC_ORR, OPC_EOR, OPC_BIC, OPC_MVN: begin
                unique case (opcode)
                    OPC_ORR: ctrl_d.lu_sel = LU_ORR;
                    OPC_EOR: ctrl_d.lu_sel = LU_EOR;
                    OPC_BIC: ctrl_d.lu_sel = LU_BIC;
                    OPC_MVN: ctrl_d.lu_sel = LU_INV;
                    default: ctrl_d.lu_sel = LU_AND;
                endcase
                ctrl_d.we  = 1'b1;
                ctrl_d.upd = set_flags ? FU_NZ : FU_NONE;
            end
            OPC_ADD, OPC_ADC: begin
                ctrl_d.use_sum = 1'b1;
                ctrl_d.cin     = (opcode == OPC_ADC) ? flags_q.c : 1'b0;
                ctrl_d.we      = 1'b1;
                ctrl_d.upd     = set_flags ? FU_ALL : FU_NONE;
            end
            OPC_CMP: begin
                ctrl_d.use_sum = 1'b1;
                ctrl_d.sub     = 1'b1;
                ctrl_d.cin     = 1'b1;
                ctrl_d.upd     = FU_ALL;
            end
            OPC_TST: begin
                ctrl_d.lu_sel = LU_AND;
                ctrl_d.upd    = FU_NZ;
            end
            OPC_TEQ: begin
                ctrl_d.lu_sel = LU_EOR;
                ctrl_d.upd    = FU_NZ;
            end
            default: ctrl_d = ctrl_d;
        endcase
    end

    dp_alu_logic #(.W(DATA_W)) u_logic (
        .a_i   (op_a),
        .b_i   (op_b),
        .sel_i (ctrl_d.lu_sel),
        .y_o   (lu_y)
    );

    dp_alu_addsub #(.W(DATA_W)) u_addsub (
        .a_i    (op_a),
        .b_i    (op_b),
        .sub_i  (ctrl_d.sub),
        .cin_i  (ctrl_d.cin),
        .sum_o  (sum),
        .cout_o (cout),
        .ovf_o  (ovf)
    );

    always_comb begin
        value_d  = ctrl_d.use_sum ? sum : lu_y;
        nzcv_d.n = value_d[DATA_W-1];
        nzcv_d.z = (value_d == ZERO_W);
        nzcv_d.c = cout;
        nzcv_d.v = ovf;
    end

    dp_alu_flags u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd_i   (ctrl_d.upd),
        .new_i   (nzcv_d),
        .flags_o (flags_q)
    );

    assign result    = ctrl_d.we ? value_d : ZERO_W;
    assign result_we = ctrl_d.we;
    assign flag_n    = flags_q.n;
    assign flag_z    = flags_q.z;
    assign flag_c    = flags_q.c;
    assign flag_v    = flags_q.v;

    AST_TESTS_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == OPC_CMP || opcode == OPC_TST || opcode == OPC_TEQ) |-> (!result_we && result == ZERO_W)); // R4

    AST_SUM_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        ((opcode == OPC_ADD || opcode == OPC_ADC) && set_flags) |=> (flag_z == ($past(result) == ZERO_W))); // R5

    AST_CMP_NO_BORROW: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == OPC_CMP) |=> (flag_c == ($past(op_a) >= $past(op_b)))); // R6

    AST_RESERVED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode > OPC_TEQ) |-> (!result_we && result == ZERO_W)); // R10

endmodule

// File: tb/dp_alu_bench.sv
module dp_alu_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [3:0]  opcode = '0;
    logic        set_flags = 1'b0;
    logic [31:0] result;
    logic        result_we;
    logic        flag_n, flag_z, flag_c, flag_v;

    int checks = 0;
    int errors = 0;
    logic m_n = 0, m_z = 0, m_c = 0, m_v = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dp_alu u_dp_alu (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .opcode(opcode),
        .set_flags(set_flags), .result(result), .result_we(result_we),
        .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // one operation: result checked mid-cycle, flags after the edge
    task automatic do_op(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic sf, input string tag);
        logic [31:0] val, er;
        logic ewe, en, ez, ec, ev, upd_nz, upd_cv, cin;
        logic [32:0] w;
        longint sfull;
        val = '0; ewe = 0; ec = m_c; ev = m_v; upd_nz = 0; upd_cv = 0;
        cin = (op == 4'd6) ? m_c : 1'b0;
        case (op)
            4'd0: val = a & b;
            4'd1: val = a | b;
            4'd2: val = a ^ b;
            4'd3: val = a & ~b;
            4'd4: val = ~b;
            4'd5, 4'd6: begin
                w = {1'b0, a} + {1'b0, b} + {32'd0, cin};
                val = w[31:0];
                ec = w[32];
                sfull = longint'($signed(a)) + longint'($signed(b)) + longint'(cin);
                ev = (sfull > 64'sd2147483647) || (sfull < -64'sd2147483648);
            end
            4'd7: begin
                val = a - b;
                ec = (a >= b);
                sfull = longint'($signed(a)) - longint'($signed(b));
                ev = (sfull > 64'sd2147483647) || (sfull < -64'sd2147483648);
            end
            4'd8: val = a & b;
            4'd9: val = a ^ b;
            default: val = '0;
        endcase
        ewe    = (op <= 4'd6);
        upd_nz = ((op <= 4'd6) && sf) || (op >= 4'd7 && op <= 4'd9);
        upd_cv = ((op == 4'd5 || op == 4'd6) && sf) || (op == 4'd7);
        er = ewe ? val : 32'd0;
        en = upd_nz ? val[31] : m_n;
        ez = upd_nz ? (val == 32'd0) : m_z;
        if (!upd_cv) begin ec = m_c; ev = m_v; end

        @(negedge clk);
        op_a = a; op_b = b; opcode = op; set_flags = sf;
        #1;
        chk(tag, "result", result, er);
        chk(tag, "result_we", {31'd0, result_we}, {31'd0, ewe});
        @(posedge clk);
        #1;
        chk(tag, "nzcv", {28'd0, flag_n, flag_z, flag_c, flag_v}, {28'd0, en, ez, ec, ev});
        m_n = en; m_z = ez; m_c = ec; m_v = ev;
    endtask

    task automatic t_reset;
        #1;
        chk("R1", "nzcv in reset", {28'd0, flag_n, flag_z, flag_c, flag_v}, 32'd0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1", "nzcv after reset", {28'd0, flag_n, flag_z, flag_c, flag_v}, 32'd0);
    endtask

    task automatic t_logic;
        for (int op = 0; op <= 4; op++) begin
            do_op(4'(op), 32'hF0F0_A5A5, 32'h0FF0_3C3C, 1'b1, "R2");
            do_op(4'(op), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R5");
            do_op(4'(op), 32'h8000_0000, 32'h0000_0000, 1'b0, "R2");
        end
    endtask

    task automatic t_arith;
        do_op(4'd5, 32'h7FFF_FFFF, 32'h0000_0001, 1'b1, "R7");
        do_op(4'd5, 32'hFFFF_FFFF, 32'h0000_0001, 1'b1, "R6");
        do_op(4'd6, 32'h0000_0010, 32'h0000_0020, 1'b0, "R3");
        do_op(4'd0, 32'h0000_0000, 32'hFFFF_FFFF, 1'b1, "R8");
        do_op(4'd6, 32'hFFFF_FFFE, 32'h0000_0001, 1'b1, "R3");
        do_op(4'd5, 32'h8000_0000, 32'h8000_0000, 1'b1, "R7");
        do_op(4'd6, 32'h1234_5678, 32'h1111_1111, 1'b1, "R3");
    endtask

    task automatic t_compare;
        do_op(4'd7, 32'h0000_0005, 32'h0000_0005, 1'b0, "R4");
        do_op(4'd7, 32'h0000_0003, 32'h0000_0005, 1'b0, "R6");
        do_op(4'd6, 32'h0000_0100, 32'h0000_0001, 1'b1, "R3");
        do_op(4'd7, 32'h8000_0000, 32'h0000_0001, 1'b1, "R7");
        do_op(4'd7, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R7");
        do_op(4'd7, 32'hFFFF_FFFF, 32'h0000_0001, 1'b0, "R6");
    endtask

    task automatic t_test;
        do_op(4'd8, 32'h00FF_0000, 32'h0000_FF00, 1'b0, "R4");
        do_op(4'd8, 32'h8000_0001, 32'h8000_0000, 1'b0, "R5");
        do_op(4'd9, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 1'b1, "R4");
        do_op(4'd9, 32'h0000_0000, 32'h8000_0000, 1'b0, "R8");
    endtask

    task automatic t_no_setflags;
        do_op(4'd5, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R6");
        for (int op = 0; op <= 6; op++)
            do_op(4'(op), 32'h0000_0000, 32'h0000_0000, 1'b0, "R9");
    endtask

    task automatic t_reserved;
        do_op(4'd7, 32'h0000_0000, 32'h0000_0001, 1'b1, "R7");
        for (int op = 10; op <= 15; op++)
            do_op(4'(op), 32'hFFFF_FFFF, 32'h0000_0001, 1'b1, "R10");
    endtask

    task automatic t_random;
        for (int i = 0; i < 300; i++) begin
            logic [31:0] a, b;
            logic [3:0] op;
            a  = $urandom;
            b  = $urandom;
            op = 4'($urandom_range(0, 9));
            if (i % 7 == 0) b = a;
            do_op(op, a, b, 1'($urandom_range(0, 1)), "R3");
        end
    endtask

    initial begin
        t_reset();
        t_logic();
        t_arith();
        t_compare();
        t_test();
        t_no_setflags();
        t_reserved();
        t_random();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule